// File: doc/BRIEF.md
# Sampling ADC Conversion Controller

This block runs a parallel-output sampling analog-to-digital converter from a synchronous system clock. While `enable` is high it drives the converter's start line with a pulse of fixed width, once every fixed number of clock cycles. The width and the period are set by parameters. The converter's busy flag is brought into the clock domain through a two-stage synchroniser. When the flag falls, the block captures the 14-bit parallel word and converts it from offset binary to two's complement. It then presents the result together with a one-cycle valid strobe.

The block protects the converter against misuse in two ways. The first is at elaboration: a width/period configuration that breaks the converter's pulse rules is refused, flagged, and never drives a pulse. The second is at run time: a start that falls due while the converter is still busy is dropped rather than issued, because a restart during a conversion would spoil two results. Two sticky flags report trouble: one for a dropped start (overrun) and one for a conversion that never finishes (timeout).

Top module: `sample_adc_ctrl`

## Requirements
- R1: While `rstN` is low and after reset, `adcStart`, `sampleValid`, `overrunFlag` and `timeoutFlag` are 0 and `sampleOut` is 0.
- R2: With `enable` high, `adcStart` rises in the cycle after `enable` is first sampled high. It stays high for exactly PULSE_CYC cycles, and it rises again every PERIOD_CYC cycles.
- R3: While `enable` is low, `adcStart` stays low.
- R4: A configuration is refused, and `cfgError` is 1 with no pulse ever issued, in any of these cases: the high time PULSE_CYC*CLK_NS is below 10 ns or strictly between 110 ns and 160 ns; the low time is below 30 ns; or the period is below 333 ns.
- R5: If the synchronised busy flag is high when a start falls due, that start is skipped (`adcStart` stays low) and `overrunFlag` is set and held until reset. A busy flag that falls in time never sets it.
- R6: If no synchronised busy-flag fall follows a start within TIMEOUT_CYC cycles, `timeoutFlag` is set in the TIMEOUT_CYC-th cycle after the start rose and is held until reset. A conversion that finishes in time never sets it.
- R7: The data bus is captured on the second clock after the synchronised fall of `adcBusy`. `sampleValid` is high for exactly one cycle, in the fourth cycle after the raw fall, and the value on the bus while busy is never presented.
- R8: `sampleOut` is the captured offset-binary word with its MSB inverted. Examples: 0x2000 gives 0, 0x3FFF gives +8191, 0x0000 gives -8192, 0x1FFF gives -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run periodic conversions |
| adcBusy | input | 1 | Converter busy flag (high during conversion), asynchronous |
| adcData | input | DATA_W | Converter parallel output word, offset binary |
| adcStart | output | 1 | Start-convert pulse to the converter |
| sampleOut | output | DATA_W | Last sample, two's complement |
| sampleValid | output | 1 | One-cycle strobe for a new sample |
| overrunFlag | output | 1 | Sticky: a start was skipped because the converter was busy |
| timeoutFlag | output | 1 | Sticky: a conversion did not finish in time |
| cfgError | output | 1 | Configuration refused; no pulses are issued |

## Verification
The first start pulse is due one cycle after `enable` is seen. The bench then measures the pulse width and the spacing between rising edges by counting falling clock edges. A sample is due four cycles after the bench drops the busy flag: two synchroniser stages, one strobe register and the output register. The bench therefore checks that `sampleValid` is low at the third falling edge, high at the fourth and low again at the fifth. The timeout flag is checked to be clear at the nineteenth falling edge after the pulse is seen and set at the twentieth. The overrun flag and the missing pulse are checked at the next due slot, which comes PERIOD_CYC cycles after the first pulse.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  // Strobes sent from the control FSM to the datapath
  typedef struct packed {
    logic capture;
  } dpStrobe_t;

  // Converter pulse rules, in nanoseconds
  localparam int MIN_HIGH_NS   = 10;
  localparam int DEAD_LO_NS    = 110;
  localparam int DEAD_HI_NS    = 160;
  localparam int MIN_LOW_NS    = 30;
  localparam int MIN_PERIOD_NS = 333;

  function automatic logic cfgIsBad(input int highNs, input int lowNs, input int periodNs);
    return (highNs < MIN_HIGH_NS) ||
           ((highNs > DEAD_LO_NS) && (highNs < DEAD_HI_NS)) ||
           (lowNs < MIN_LOW_NS) ||
           (periodNs < MIN_PERIOD_NS);
  endfunction

endpackage

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
  import sadc_pkg::*;
#(
  parameter int PERIOD_CYC  = 34,
  parameter int PULSE_CYC   = 2,
  parameter int CLK_NS      = 10,
  parameter int TIMEOUT_CYC = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       adcBusy,
  output logic       adcStart,
  output logic       overrunFlag,
  output logic       timeoutFlag,
  output logic       cfgError,
  output dpStrobe_t  dpStb
);

  localparam int  PC_W   = $clog2(PERIOD_CYC + 1);
  localparam int  WL_W   = $clog2(PULSE_CYC + 1);
  localparam int  WT_W   = $clog2(TIMEOUT_CYC + 1);
  localparam logic CFG_BAD = cfgIsBad(PULSE_CYC * CLK_NS,
                                      (PERIOD_CYC - PULSE_CYC) * CLK_NS,
                                      PERIOD_CYC * CLK_NS);

  logic            busyMeta, busySync, busySyncD;
  logic            busyFall, due;
  logic [PC_W-1:0] periodCnt;
  logic [WL_W-1:0] widthLeft;
  logic [WT_W-1:0] waitCnt;
  logic            startReg, awaiting, captureStb;

  assign busyFall = busySyncD & ~busySync;
  assign due      = enable & ~CFG_BAD & (periodCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyMeta    <= 1'b0;
      busySync    <= 1'b0;
      busySyncD   <= 1'b0;
      captureStb  <= 1'b0;
      periodCnt   <= '0;
      widthLeft   <= '0;
      waitCnt     <= '0;
      startReg    <= 1'b0;
      awaiting    <= 1'b0;
      overrunFlag <= 1'b0;
      timeoutFlag <= 1'b0;
    end else begin
      busyMeta   <= adcBusy;
      busySync   <= busyMeta;
      busySyncD  <= busySync;
      captureStb <= busyFall;

      if (!enable || CFG_BAD)
        periodCnt <= '0;
      else if (periodCnt == PC_W'(PERIOD_CYC - 1))
        periodCnt <= '0;
      else
        periodCnt <= periodCnt + 1'b1;

      if (startReg) begin
        if (widthLeft == '0) startReg <= 1'b0;
        else                 widthLeft <= widthLeft - 1'b1;
      end

      if (awaiting) begin
        if (busyFall) begin
          awaiting <= 1'b0;
        end else if (waitCnt == WT_W'(TIMEOUT_CYC - 1)) begin
          timeoutFlag <= 1'b1;
          awaiting    <= 1'b0;
        end else begin
          waitCnt <= waitCnt + 1'b1;
        end
      end

      if (due) begin
        if (busySync) begin
          overrunFlag <= 1'b1;
        end else begin
          startReg  <= 1'b1;
          widthLeft <= WL_W'(PULSE_CYC - 1);
          awaiting  <= 1'b1;
          waitCnt   <= '0;
        end
      end
    end
  end

  assign adcStart      = startReg;
  assign cfgError      = CFG_BAD;
  assign dpStb.capture = captureStb;

  // R2: the pulse is not cut short while width remains
  a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rstN)
    (startReg && widthLeft != '0) |=> startReg);

  // R5: no pulse starts on a slot where the converter looked busy
  a_r5_no_start_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startReg) |-> !$past(busySync));

  a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrunFlag |=> overrunFlag);

  a_r6_timeout_sticky: assert property (@(posedge clk) disable iff (!rstN)
    timeoutFlag |=> timeoutFlag);

endmodule

// File: rtl/sadc_datapath.sv
module sadc_datapath
  import sadc_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                dpStb,
  input  logic [DATA_W-1:0]        adcData,
  output logic signed [DATA_W-1:0] sampleOut,
  output logic                     sampleValid
);

  localparam int MSB = DATA_W - 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleOut   <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= dpStb.capture;
      if (dpStb.capture)
        sampleOut <= {~adcData[MSB], adcData[MSB-1:0]};
    end
  end

  // R7: a sample strobe never lasts two cycles
  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R8: sign bit is the inverse of the captured MSB
  a_r8_sign_flip: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (sampleOut[MSB] != $past(adcData[MSB])));

endmodule

// File: rtl/sample_adc_ctrl.sv
module sample_adc_ctrl
  import sadc_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int PERIOD_CYC  = 34,
  parameter int PULSE_CYC   = 2,
  parameter int CLK_NS      = 10,
  parameter int TIMEOUT_CYC = 20
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     enable,
  input  logic                     adcBusy,
  input  logic [DATA_W-1:0]        adcData,
  output logic                     adcStart,
  output logic signed [DATA_W-1:0] sampleOut,
  output logic                     sampleValid,
  output logic                     overrunFlag,
  output logic                     timeoutFlag,
  output logic                     cfgError
);

  dpStrobe_t dpStb;

  sadc_ctrl #(
    .PERIOD_CYC (PERIOD_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .CLK_NS     (CLK_NS),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .adcBusy    (adcBusy),
    .adcStart   (adcStart),
    .overrunFlag(overrunFlag),
    .timeoutFlag(timeoutFlag),
    .cfgError   (cfgError),
    .dpStb      (dpStb)
  );

  sadc_datapath #(
    .DATA_W(DATA_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .dpStb      (dpStb),
    .adcData    (adcData),
    .sampleOut  (sampleOut),
    .sampleValid(sampleValid)
  );

endmodule

// File: tb/sample_adc_ctrl_tb_top.sv
module sample_adc_ctrl_tb_top;

  localparam int DATA_W  = 14;
  localparam int PERIOD  = 20;
  localparam int PULSE   = 2;
  localparam int TIMEOUT = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic adcBusy = 1'b0;
  logic [DATA_W-1:0] adcData = '0;

  logic adcStart, sampleValid, overrunFlag, timeoutFlag, cfgError;
  logic signed [DATA_W-1:0] sampleOut;
  logic badStart, badValid, badOverrun, badTimeout, badCfg;
  logic signed [DATA_W-1:0] badSample;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  sample_adc_ctrl #(.DATA_W(DATA_W), .PERIOD_CYC(PERIOD), .PULSE_CYC(PULSE),
                    .CLK_NS(20), .TIMEOUT_CYC(TIMEOUT)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .adcBusy(adcBusy), .adcData(adcData),
    .adcStart(adcStart), .sampleOut(sampleOut), .sampleValid(sampleValid),
    .overrunFlag(overrunFlag), .timeoutFlag(timeoutFlag), .cfgError(cfgError));

  // 6 cycles * 20 ns = 120 ns high time: inside the forbidden zone
  sample_adc_ctrl #(.DATA_W(DATA_W), .PERIOD_CYC(PERIOD), .PULSE_CYC(6),
                    .CLK_NS(20), .TIMEOUT_CYC(TIMEOUT)) bad_i (
    .clk(clk), .rstN(rstN), .enable(enable), .adcBusy(adcBusy), .adcData(adcData),
    .adcStart(badStart), .sampleOut(badSample), .sampleValid(badValid),
    .overrunFlag(badOverrun), .timeoutFlag(badTimeout), .cfgError(badCfg));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    enable = 1'b0; adcBusy = 1'b0; adcData = '0; rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitRise();
    int n = 0;
    while (adcStart !== 1'b1 && n < 60) begin
      @(negedge clk);
      n++;
    end
    check("R2 pulse seen", int'(adcStart), 1);
  endtask

  task automatic testReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 start in reset", int'(adcStart), 0);
    check("R1 valid in reset", int'(sampleValid), 0);
    check("R1 sample in reset", int'(sampleOut), 0);
    doReset();
    check("R1 overrun after reset", int'(overrunFlag), 0);
    check("R1 timeout after reset", int'(timeoutFlag), 0);
    check("R4 good config accepted", int'(cfgError), 0);
  endtask

  task automatic testPulseTiming();
    int width = 0;
    int gap = 0;
    doReset();
    enable = 1'b1;
    @(negedge clk);
    check("R2 first pulse one cycle after enable", int'(adcStart), 1);
    while (adcStart === 1'b1 && width < 50) begin width++; @(negedge clk); end
    check("R2 pulse width", width, PULSE);
    gap = width;
    while (adcStart !== 1'b1 && gap < 100) begin gap++; @(negedge clk); end
    check("R2 period", gap, PERIOD);
    enable = 1'b0;
    @(negedge clk);
    width = 0;
    for (int i = 0; i < 3 * PERIOD; i++) begin
      @(negedge clk);
      if (adcStart) width++;
    end
    check("R3 no pulse while disabled", width, 0);
  endtask

  task automatic convertOne(input logic [DATA_W-1:0] code, input int expVal);
    waitRise();
    adcBusy = 1'b1;
    adcData = ~code;  // bus content while busy must never appear
    repeat (6) @(negedge clk);
    adcBusy = 1'b0;
    adcData = code;
    repeat (3) @(negedge clk);
    check("R7 valid not early", int'(sampleValid), 0);
    @(negedge clk);
    check("R7 valid on fourth cycle", int'(sampleValid), 1);
    check("R8 two's complement value", int'(sampleOut), expVal);
    @(negedge clk);
    check("R7 valid one cycle", int'(sampleValid), 0);
  endtask

  task automatic testConversions();
    doReset();
    enable = 1'b1;
    convertOne(14'h2000, 0);
    convertOne(14'h3FFF, 8191);
    convertOne(14'h0000, -8192);
    convertOne(14'h1FFF, -1);
    convertOne(14'h2ABC, 2748);
    check("R8 value held after strobe", int'(sampleOut), 2748);
    check("R5 no overrun on timely conversions", int'(overrunFlag), 0);
    check("R6 no timeout on timely conversions", int'(timeoutFlag), 0);
    enable = 1'b0;
  endtask

  task automatic testTimeout();
    doReset();
    enable = 1'b1;
    waitRise();
    repeat (TIMEOUT - 1) @(negedge clk);
    check("R6 timeout not early", int'(timeoutFlag), 0);
    @(negedge clk);
    check("R6 timeout set", int'(timeoutFlag), 1);
    enable = 1'b0;
    repeat (30) @(negedge clk);
    check("R6 timeout sticky", int'(timeoutFlag), 1);
    check("R5 no overrun when busy never rose", int'(overrunFlag), 0);
  endtask

  task automatic testOverrun();
    int highs = 0;
    doReset();
    enable = 1'b1;
    waitRise();
    adcBusy = 1'b1;  // converter never finishes
    repeat (PERIOD - 1) @(negedge clk);
    check("R5 overrun not early", int'(overrunFlag), 0);
    @(negedge clk);
    check("R5 overrun set at due slot", int'(overrunFlag), 1);
    check("R5 skipped start low", int'(adcStart), 0);
    for (int i = 0; i < 2 * PERIOD; i++) begin
      @(negedge clk);
      if (adcStart) highs++;
    end
    check("R5 no start while busy", highs, 0);
    adcBusy = 1'b0;
    enable = 1'b0;
    repeat (10) @(negedge clk);
    check("R5 overrun sticky", int'(overrunFlag), 1);
  endtask

  task automatic testBadConfig();
    int highs = 0;
    doReset();
    enable = 1'b1;
    for (int i = 0; i < 3 * PERIOD; i++) begin
      @(negedge clk);
      if (badStart) highs++;
    end
    check("R4 forbidden width flagged", int'(badCfg), 1);
    check("R4 refused config never pulses", highs, 0);
    enable = 1'b0;
  endtask

  initial begin
    testReset();
    testPulseTiming();
    testConversions();
    testTimeout();
    testOverrun();
    testBadConfig();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule